// File: doc/BRIEF.md
# Scalar-Issue Vector Instruction Expander

This block turns a single three-register arithmetic instruction into a stream of scalar instructions, one for each element of a vector. The instruction (an opcode, a destination and two sources) arrives with a vector length over a valid/ready handshake. A table of 32 flags marks each architectural register as vectorised or scalar. For element `i`, every operand whose register is flagged vectorised uses its base number plus `i`. Every operand that is not flagged keeps its base number. The scalar instructions are written into an output FIFO in element order, and a downstream issue stage drains them with its own valid/ready handshake.

Register numbers never wrap. Before each element is pushed, the block checks all three computed register numbers. If any of them would pass the last register (31), the block raises a one-cycle exception pulse and stops the expansion. Elements already pushed stay in the FIFO. A vector length of zero is accepted and completes at once with no output. The flag table has a single write port and clears on reset. The flags for an instruction are captured at the moment it is accepted.

Top module: `vec_expander`

## Requirements
- R1: With vector length N and no register overflow, exactly N entries leave the FIFO for the accepted instruction, in element order 0..N-1.
- R2: In element i, an operand whose flag is 1 (vectorised) carries its base register number plus i.
- R3: An operand whose flag is 0 (scalar) carries its base register number in every element.
- R4: Every generated entry carries the accepted opcode unchanged.
- R5: If any vectorised operand of element i would exceed 31, element i and all later elements are not pushed. `exc_o` is high for exactly one cycle, and the block then returns to idle. Elements before i are still delivered.
- R6: A vector length of 0 produces no entries and no exception, and `busy_o` stays low after acceptance.
- R7: `in_ready` is low whenever an expansion is in progress (`busy_o` high) or the FIFO is full.
- R8: While the consumer holds `out_ready` low, the FIFO head stays stable. Expansion stalls on a full FIFO with no element lost or duplicated.
- R9: Flags are sampled when the instruction is accepted. Flag writes made during an expansion do not change that expansion's output.
- R10: After reset, `out_valid` is 0, `in_ready` is 1, `busy_o` is 0, and every flag is 0 (scalar).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Flag table write enable |
| flag_idx | input | 5 | Register whose flag is written |
| flag_val | input | 1 | Flag value: 1 = vectorised, 0 = scalar |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be accepted |
| in_opc | input | 4 | Opcode |
| in_rd | input | 5 | Destination base register |
| in_rs1 | input | 5 | First source base register |
| in_rs2 | input | 5 | Second source base register |
| in_vl | input | VL_W (6) | Vector length |
| out_valid | output | 1 | FIFO head holds a scalar instruction |
| out_ready | input | 1 | Consumer takes the head |
| out_opc | output | 4 | Head opcode |
| out_rd | output | 5 | Head destination register |
| out_rs1 | output | 5 | Head first source register |
| out_rs2 | output | 5 | Head second source register |
| exc_o | output | 1 | One-cycle register-overflow exception |
| busy_o | output | 1 | Expansion in progress |

## Verification
The bench sweeps every combination of the three operand flags against vector lengths 0 to 5. It uses base registers both low and near the top of the file, so that overflow happens on different elements. A design that wrapped numbers, or that checked only the destination, would deliver extra or wrong entries. A design that pushed the faulting element would deliver one entry too many. The consumer holds stalls longer than the FIFO depth, so a design that pushed into a full FIFO or advanced its element index during a stall would lose or repeat elements. Further cases are run separately: aliased sources, vector length zero, flags left at their reset value, and a flag rewritten mid-expansion. Each catches a design that idles wrongly, fails to clear its flags, or reads flags live instead of at acceptance.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int REG_W = 5;
  localparam int OPC_W = 4;
  localparam int NREG  = 1 << REG_W;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
  } uop_t;
endpackage

// File: rtl/vx_flag_table.sv
module vx_flag_table
  import vx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] widx,
  input  logic             wval,
  output logic [NREG-1:0]  flags
);
  logic [NREG-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (we) flags_d[widx] = wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (we) flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/vx_fifo.sv
module vx_fifo
  import vx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  uop_t wdata,
  output logic full,
  output logic valid,
  input  logic pop,
  output uop_t rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  uop_t mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
endmodule

// File: rtl/vx_seq.sv
module vx_seq
  import vx_pkg::*;
#(
  parameter int VL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  uop_t             in_uop,
  input  logic [VL_W-1:0]  in_vl,
  input  logic [NREG-1:0]  flags,
  input  logic             fifo_full,
  output logic             push,
  output uop_t             push_uop,
  output logic             exc,
  output logic             busy
);
  localparam int SUM_W = ((REG_W > VL_W) ? REG_W : VL_W) + 1;
  localparam int NOPS  = 3;

  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t                          st_q, st_d;
  logic [OPC_W-1:0]             opc_q;
  logic [NOPS-1:0][REG_W-1:0]   base_q;
  logic [NOPS-1:0]              vmask_q;
  logic [VL_W-1:0]              vl_q, idx_q, idx_d;
  logic [NOPS-1:0][REG_W-1:0]   in_base;
  logic [NOPS-1:0]              in_vmask;
  logic [NOPS-1:0][REG_W-1:0]   elem_reg;
  logic [NOPS-1:0]              elem_ovf;
  logic                         accept, load_en, step_en, last, ovf;

  assign in_base = {in_uop.rd, in_uop.rs1, in_uop.rs2};

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    logic [SUM_W-1:0] sum;
    assign in_vmask[g] = flags[in_base[g]];
    assign sum         = SUM_W'(base_q[g]) + (vmask_q[g] ? SUM_W'(idx_q) : '0);
    assign elem_reg[g] = sum[REG_W-1:0];
    assign elem_ovf[g] = |sum[SUM_W-1:REG_W];
  end

  assign in_ready = (st_q == S_IDLE) && !fifo_full;
  assign accept   = in_valid && in_ready;
  assign busy     = (st_q == S_RUN);
  assign ovf      = busy && (|elem_ovf);
  assign exc      = ovf;
  assign push     = busy && !ovf && !fifo_full;
  assign last     = (idx_q == vl_q - VL_W'(1));
  assign load_en  = accept && (in_vl != '0);
  assign step_en  = push;

  assign push_uop = '{opc: opc_q, rd: elem_reg[2], rs1: elem_reg[1], rs2: elem_reg[0]};

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      S_IDLE: begin
        if (load_en) begin
          st_d  = S_RUN;
          idx_d = '0;
        end
      end
      S_RUN: begin
        if (ovf) begin
          st_d = S_IDLE;
        end else if (step_en) begin
          if (last) st_d = S_IDLE;
          else      idx_d = idx_q + VL_W'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q   <= '0;
      base_q  <= '0;
      vmask_q <= '0;
      vl_q    <= '0;
    end else if (load_en) begin
      opc_q   <= in_uop.opc;
      base_q  <= in_base;
      vmask_q <= in_vmask;
      vl_q    <= in_vl;
    end
  end
endmodule

// File: rtl/vec_expander.sv
module vec_expander
  import vx_pkg::*;
#(
  parameter int VL_W       = 6,
  parameter int FIFO_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_we,
  input  logic [REG_W-1:0] flag_idx,
  input  logic             flag_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_opc,
  input  logic [REG_W-1:0] in_rd,
  input  logic [REG_W-1:0] in_rs1,
  input  logic [REG_W-1:0] in_rs2,
  input  logic [VL_W-1:0]  in_vl,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OPC_W-1:0] out_opc,
  output logic [REG_W-1:0] out_rd,
  output logic [REG_W-1:0] out_rs1,
  output logic [REG_W-1:0] out_rs2,
  output logic             exc_o,
  output logic             busy_o
);
  logic [NREG-1:0] flags;
  logic            fifo_full, push;
  uop_t            push_uop, head, in_uop;

  assign in_uop = '{opc: in_opc, rd: in_rd, rs1: in_rs1, rs2: in_rs2};

  vx_flag_table u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .widx(flag_idx),
    .wval(flag_val), .flags(flags)
  );

  vx_seq #(.VL_W(VL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_uop(in_uop), .in_vl(in_vl), .flags(flags), .fifo_full(fifo_full),
    .push(push), .push_uop(push_uop), .exc(exc_o), .busy(busy_o)
  );

  vx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(push_uop),
    .full(fifo_full), .valid(out_valid), .pop(out_ready), .rdata(head)
  );

  assign out_opc = head.opc;
  assign out_rd  = head.rd;
  assign out_rs1 = head.rs1;
  assign out_rs2 = head.rs2;
endmodule

// File: rtl/vx_checker.sv
module vx_checker #(
  parameter int VL_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VL_W-1:0] in_vl,
  input logic            out_valid,
  input logic            out_ready,
  input logic [3:0]      out_opc,
  input logic [4:0]      out_rd,
  input logic [4:0]      out_rs1,
  input logic [4:0]      out_rs2,
  input logic            exc_o,
  input logic            busy_o
);
  // R7
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !in_ready);

  // R5
  exc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |=> !exc_o && !busy_o);

  // R5
  exc_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> busy_o);

  // R6
  zero_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_vl == '0) |=> !busy_o);

  // R1
  start_expand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_vl != '0) |=> busy_o);

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_opc) && $stable(out_rd)
      && $stable(out_rs1) && $stable(out_rs2));
endmodule

bind vec_expander vx_checker #(.VL_W(VL_W)) u_vx_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_vl(in_vl), .out_valid(out_valid), .out_ready(out_ready),
  .out_opc(out_opc), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
  .exc_o(exc_o), .busy_o(busy_o)
);

// File: tb/vec_expander_tb_top.sv
module vec_expander_tb_top;
  localparam int VL_W  = 6;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic flag_we, flag_val, in_valid, out_ready;
  logic [4:0] flag_idx, in_rd, in_rs1, in_rs2;
  logic [3:0] in_opc;
  logic [VL_W-1:0] in_vl;
  logic in_ready, out_valid, exc_o, busy_o;
  logic [3:0] out_opc;
  logic [4:0] out_rd, out_rs1, out_rs2;

  int checks = 0;
  int failures = 0;
  int exc_seen = 0;
  int cycles = 0;
  bit [31:0] mflags;
  logic [18:0] expq [$];

  always #4 clk = ~clk;

  vec_expander #(.VL_W(VL_W), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_idx(flag_idx),
    .flag_val(flag_val), .in_valid(in_valid), .in_ready(in_ready),
    .in_opc(in_opc), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_vl(in_vl), .out_valid(out_valid), .out_ready(out_ready),
    .out_opc(out_opc), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .exc_o(exc_o), .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // consumer with stall bursts longer than the FIFO depth, plus monitors
  always @(negedge clk) begin
    logic rdy;
    cycles++;
    rdy = rst_n && (cycles[5:3] != 3'b111) && (cycles[1:0] != 2'b00);
    out_ready = rdy;
    if (rst_n) begin
      if (exc_o) exc_seen++;
      if (busy_o) chk(!in_ready, "R7 in_ready while busy", int'(in_ready), 0);
      if (out_valid && rdy) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R1/R5 unexpected entry rd", int'(out_rd), -1);
        end else begin
          logic [18:0] e;
          e = expq.pop_front();
          chk(out_opc == e[18:15], "R4 opcode", int'(out_opc), int'(e[18:15]));
          chk(out_rd  == e[14:10], "R2/R3/R8 rd", int'(out_rd), int'(e[14:10]));
          chk(out_rs1 == e[9:5],   "R2/R3/R8 rs1", int'(out_rs1), int'(e[9:5]));
          chk(out_rs2 == e[4:0],   "R2/R3/R8 rs2", int'(out_rs2), int'(e[4:0]));
        end
      end
    end
  end

  task automatic set_flag(input int r, input bit v);
    @(negedge clk);
    flag_we = 1'b1; flag_idx = 5'(r); flag_val = v;
    @(negedge clk);
    flag_we = 1'b0;
    mflags[r] = v;
  endtask

  task automatic run_op(input int opc, input int rd, input int rs1, input int rs2,
                        input int vl, input bit flip_rd, input string tag);
    bit exp_exc = 0;
    int exc0;
    for (int i = 0; i < vl; i++) begin
      int a, b, c;
      a = rd  + (mflags[rd]  ? i : 0);
      b = rs1 + (mflags[rs1] ? i : 0);
      c = rs2 + (mflags[rs2] ? i : 0);
      if (a > 31 || b > 31 || c > 31) begin exp_exc = 1; break; end
      expq.push_back({4'(opc), 5'(a), 5'(b), 5'(c)});
    end
    exc0 = exc_seen;
    @(negedge clk);
    in_valid = 1'b1; in_opc = 4'(opc); in_rd = 5'(rd); in_rs1 = 5'(rs1);
    in_rs2 = 5'(rs2); in_vl = VL_W'(vl);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (vl == 0) chk(!busy_o, {"R6 busy after zero length ", tag}, int'(busy_o), 0);
    // R9: rewrite a flag while the expansion runs; output must not change
    if (flip_rd) set_flag(rd, !mflags[rd]);
    while (expq.size() != 0 || busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exc_seen - exc0 == int'(exp_exc), {"R5 exception count ", tag},
        exc_seen - exc0, int'(exp_exc));
  endtask

  initial begin
    rst_n = 1'b0; flag_we = 0; flag_idx = '0; flag_val = 0; in_valid = 0;
    in_opc = '0; in_rd = '0; in_rs1 = '0; in_rs2 = '0; in_vl = '0;
    out_ready = 0; mflags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!out_valid, "R10 out_valid", int'(out_valid), 0);
    chk(in_ready,   "R10 in_ready", int'(in_ready), 1);
    chk(!busy_o,    "R10 busy", int'(busy_o), 0);
    // R10 flags cleared: everything stays scalar
    run_op(3, 9, 10, 11, 3, 0, "R10 flags cleared");
    // R2 all operands vectorised, aliased sources
    set_flag(7, 1); set_flag(4, 1);
    run_op(1, 7, 4, 4, 3, 0, "R2 aliased");
    // R3 one scalar source
    set_flag(1, 1); set_flag(4, 0);
    run_op(1, 7, 4, 1, 3, 0, "R3 mixed");
    // R5 overflow on the third element of the destination
    set_flag(30, 1);
    run_op(5, 30, 2, 3, 4, 0, "R5 directed");
    // R9 flag flipped during expansion
    set_flag(5, 1);
    run_op(6, 5, 12, 13, 5, 1, "R9 flip");
    // sweep: flags x vector length x base positions (R1, R2, R3, R5, R6, R8)
    for (int b = 0; b < 4; b++)
      for (int f = 0; f < 8; f++)
        for (int v = 0; v < 6; v++) begin
          int rd, rs1;
          rd  = b[0] ? 28 : 2;
          rs1 = b[1] ? 30 : 12;
          set_flag(rd, f[2]); set_flag(rs1, f[1]); set_flag(20, f[0]);
          run_op(f + v, rd, rs1, 20, v, 0, "R1 sweep");
        end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule